// File: doc/BRIEF.md
# Pack, Rotate and Negated-Logic ALU Slice

This block is a purely combinational execution slice for the base bit-manipulation group used by scalar cryptography code. It takes two register operands, the instruction's major opcode, its three-bit minor function field and its seven-bit upper function field, plus a single configuration bit that selects between a 32-bit and a 64-bit machine. From these it produces one result word and an illegal flag. The slice covers three families: field packing (halves, low bytes, and the word form on 64-bit machines), bitwise logic with an inverted second operand, and rotation in both directions (register amount, immediate amount, and word-sized forms on 64-bit machines).

Decoding is done in two steps. The field combination is first mapped to one value of an enumerated operation type, with `OP_NONE` as the catch-all for anything outside the slice. That value then steers a result multiplexer over three small units: a packer, a logic unit and a pair of rotators, one sized for the full word and one for half of it. Zero-extending a halfword is not decoded separately. It falls out of the pack forms when the second operand is zero. For immediate rotates the pipeline places the shift amount on the second operand. The upper function field still has to be checked, because its lowest bit is the top bit of a 64-bit shift amount.

In 32-bit mode only the low half of each operand is used and the upper half of the result is zero. The slice has no clock, no state and no handshake. A caller registers the result wherever its pipeline needs it.

Top module: `pkb_alu`

## Requirements
- R1: Pack (major 0110011, minor 100, upper 0000100) returns the low half-width bits of operand A in the lower half of the result and those of operand B in the upper half; in 32-bit mode the halves are 16 bits each and bits 63:32 are zero.
- R2: Byte pack (major 0110011, minor 111, upper 0000100) returns operand A bits 7:0 in result bits 7:0 and operand B bits 7:0 in result bits 15:8, with every higher bit zero, in both modes.
- R3: Word pack (major 0111011, minor 100, upper 0000100) is legal only in 64-bit mode: it forms {B[15:0], A[15:0]} as a 32-bit value and sign-extends it from bit 31; in 32-bit mode it is illegal.
- R4: With operand B equal to zero, pack in 32-bit mode and word pack in 64-bit mode both return A[15:0] zero-extended (halfword zero-extend).
- R5: Under major 0110011 with upper field 0100000, minor 111 gives A & ~B, minor 110 gives A | ~B and minor 100 gives ~(A ^ B).
- R6: Under major 0110011 with upper field 0110000, minor 001 rotates A left and minor 101 rotates A right by B modulo the word width (64 or 32 according to the mode).
- R7: Immediate rotate right (major 0010011, minor 101, upper bits 6:1 equal 011000) rotates A right by B modulo the word width; an upper field with bit 0 set is legal only in 64-bit mode.
- R8: In 64-bit mode, word rotates (major 0111011, upper 0110000, minor 001 left, minor 101 right; and major 0011011, minor 101, upper 0110000 right) rotate A[31:0] by B modulo 32 and sign-extend from bit 31, ignoring A[63:32]; in 32-bit mode they are illegal.
- R9: Any field combination outside R1 to R8, or illegal for the selected mode, raises the illegal flag and drives a zero result; legal combinations keep the flag low.
- R10: In 32-bit mode (wide_mode = 0) result bits 63:32 are zero and operand bits 63:32 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wide_mode | input | 1 | 1 selects a 64-bit machine, 0 a 32-bit machine |
| major_op | input | 7 | Major opcode field of the instruction |
| minor_op | input | 3 | Three-bit minor function field |
| func_hi | input | 7 | Seven-bit upper function field |
| opnd_a | input | 64 | First source operand |
| opnd_b | input | 64 | Second source operand, or the rotate amount for immediate forms |
| result | output | 64 | Operation result, zero when illegal |
| illegal | output | 1 | High when the field combination is not legal for the mode |

## Verification
The packing forms use operands whose every nibble differs, so any half or byte drawn from the wrong place or the wrong operand shows up. Swapping the operands for word pack gives one result with bit 31 set and one with it clear, which separates sign extension from zero extension. The logic forms use a mask with mixed bytes and nibbles, so inverting the wrong operand gives a different value. Rotate amounts of zero, of the width plus four, and of one less than the width check the modulo and wrap paths. Word rotates run with garbage in A[63:32] and with results of both signs. A sweep over neighbouring, unassigned field combinations and mode-illegal forms confirms that the flag is set and the result is zero.

// File: rtl/pkb_pkg.sv
package pkb_pkg;

    localparam logic [6:0] MAJ_REG   = 7'b0110011;
    localparam logic [6:0] MAJ_REGW  = 7'b0111011;
    localparam logic [6:0] MAJ_IMM   = 7'b0010011;
    localparam logic [6:0] MAJ_IMMW  = 7'b0011011;

    localparam logic [6:0] UP_PACK   = 7'b0000100;
    localparam logic [6:0] UP_NLOGIC = 7'b0100000;
    localparam logic [6:0] UP_ROT    = 7'b0110000;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_PACK,
        OP_PACKH,
        OP_PACKW,
        OP_ANDN,
        OP_ORN,
        OP_XNOR,
        OP_ROL,
        OP_ROR,
        OP_ROLW,
        OP_RORW
    } pkb_op_e;

endpackage

// File: rtl/pkb_decode.sv
module pkb_decode
    import pkb_pkg::*;
(
    input  logic       wide_mode,
    input  logic [6:0] major_op,
    input  logic [2:0] minor_op,
    input  logic [6:0] func_hi,
    output pkb_op_e    op
);

    always_comb begin
        op = OP_NONE;
        unique case (major_op)
            MAJ_REG: begin
                unique case ({func_hi, minor_op})
                    {UP_PACK,   3'b100}: op = OP_PACK;
                    {UP_PACK,   3'b111}: op = OP_PACKH;
                    {UP_NLOGIC, 3'b111}: op = OP_ANDN;
                    {UP_NLOGIC, 3'b110}: op = OP_ORN;
                    {UP_NLOGIC, 3'b100}: op = OP_XNOR;
                    {UP_ROT,    3'b001}: op = OP_ROL;
                    {UP_ROT,    3'b101}: op = OP_ROR;
                    default:             op = OP_NONE;
                endcase
            end
            MAJ_REGW: begin
                if (wide_mode) begin
                    unique case ({func_hi, minor_op})
                        {UP_PACK, 3'b100}: op = OP_PACKW;
                        {UP_ROT,  3'b001}: op = OP_ROLW;
                        {UP_ROT,  3'b101}: op = OP_RORW;
                        default:           op = OP_NONE;
                    endcase
                end
            end
            MAJ_IMM: begin
                // upper bit 0 is the top shift-amount bit: only a 64-bit machine has it
                if (minor_op == 3'b101 && func_hi[6:1] == UP_ROT[6:1] &&
                    (wide_mode || !func_hi[0]))
                    op = OP_ROR;
            end
            MAJ_IMMW: begin
                if (wide_mode && minor_op == 3'b101 && func_hi == UP_ROT)
                    op = OP_RORW;
            end
            default: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/pkb_pack.sv
module pkb_pack #(
    parameter int XW = 64,
    localparam int HW = XW / 2,
    localparam int QW = XW / 4
) (
    input  logic [HW-1:0] lo_a,
    input  logic [HW-1:0] lo_b,
    output logic [XW-1:0] pk_full,
    output logic [HW-1:0] pk_half,
    output logic [15:0]   pk_byte,
    output logic [XW-1:0] pk_word
);

    logic [HW-1:0] word_raw;

    always_comb begin
        pk_full  = {lo_b, lo_a};
        pk_half  = {lo_b[QW-1:0], lo_a[QW-1:0]};
        pk_byte  = {lo_b[7:0], lo_a[7:0]};
        word_raw = {lo_b[QW-1:0], lo_a[QW-1:0]};
        pk_word  = {{HW{word_raw[HW-1]}}, word_raw};
    end

endmodule

// File: rtl/pkb_logic.sv
module pkb_logic
    import pkb_pkg::*;
#(
    parameter int XW = 64
) (
    input  pkb_op_e       op,
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    output logic [XW-1:0] y
);

    always_comb begin
        unique case (op)
            OP_ANDN: y = a & ~b;
            OP_ORN:  y = a | ~b;
            OP_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pkb_rot.sv
module pkb_rot #(
    parameter int RW = 64,
    localparam int AW = $clog2(RW)
) (
    input  logic [RW-1:0] din,
    input  logic [AW-1:0] amt,
    input  logic          to_left,
    output logic [RW-1:0] dout
);

    logic [2*RW-1:0] dbl;

    always_comb begin
        if (to_left) begin
            dbl  = {din, din} << amt;
            dout = dbl[2*RW-1:RW];
        end else begin
            dbl  = {din, din} >> amt;
            dout = dbl[RW-1:0];
        end
    end

endmodule

// File: rtl/pkb_alu.sv
module pkb_alu
    import pkb_pkg::*;
#(
    parameter int XW = 64,
    localparam int HW  = XW / 2,
    localparam int FAW = $clog2(XW),
    localparam int HAW = $clog2(HW)
) (
    input  logic          wide_mode,
    input  logic [6:0]    major_op,
    input  logic [2:0]    minor_op,
    input  logic [6:0]    func_hi,
    input  logic [XW-1:0] opnd_a,
    input  logic [XW-1:0] opnd_b,
    output logic [XW-1:0] result,
    output logic          illegal
);

    pkb_op_e       op;
    logic [XW-1:0] pk_full, pk_word, lg_y;
    logic [HW-1:0] pk_half;
    logic [15:0]   pk_byte;
    logic          rot_left;
    logic [XW-1:0] rot_full;
    logic [HW-1:0] rot_half;

    pkb_decode u_dec (
        .wide_mode (wide_mode),
        .major_op  (major_op),
        .minor_op  (minor_op),
        .func_hi   (func_hi),
        .op        (op)
    );

    pkb_pack #(.XW(XW)) u_pack (
        .lo_a    (opnd_a[HW-1:0]),
        .lo_b    (opnd_b[HW-1:0]),
        .pk_full (pk_full),
        .pk_half (pk_half),
        .pk_byte (pk_byte),
        .pk_word (pk_word)
    );

    pkb_logic #(.XW(XW)) u_logic (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (lg_y)
    );

    assign rot_left = (op == OP_ROL) || (op == OP_ROLW);

    // one rotator per supported width; a width-specific amount field gives the modulo
    for (genvar g = 0; g < 2; g++) begin : g_rot
        if (g == 0) begin : g_full
            pkb_rot #(.RW(XW)) u_rot (
                .din     (opnd_a),
                .amt     (opnd_b[FAW-1:0]),
                .to_left (rot_left),
                .dout    (rot_full)
            );
        end else begin : g_half
            pkb_rot #(.RW(HW)) u_rot (
                .din     (opnd_a[HW-1:0]),
                .amt     (opnd_b[HAW-1:0]),
                .to_left (rot_left),
                .dout    (rot_half)
            );
        end
    end

    always_comb begin
        result = '0;
        unique case (op)
            OP_PACK:                 result = wide_mode ? pk_full : {{HW{1'b0}}, pk_half};
            OP_PACKH:                result = {{(XW-16){1'b0}}, pk_byte};
            OP_PACKW:                result = pk_word;
            OP_ANDN, OP_ORN, OP_XNOR:
                                     result = wide_mode ? lg_y : {{HW{1'b0}}, lg_y[HW-1:0]};
            OP_ROL, OP_ROR:          result = wide_mode ? rot_full : {{HW{1'b0}}, rot_half};
            OP_ROLW, OP_RORW:        result = {{HW{rot_half[HW-1]}}, rot_half};
            default:                 result = '0;
        endcase
    end

    assign illegal = (op == OP_NONE);

endmodule

// File: rtl/pkb_alu_chk.sv
module pkb_alu_chk #(
    parameter int XW = 64,
    localparam int HW = XW / 2
) (
    input logic          wide_mode,
    input logic [6:0]    major_op,
    input logic [2:0]    minor_op,
    input logic [6:0]    func_hi,
    input logic [XW-1:0] opnd_a,
    input logic [XW-1:0] opnd_b,
    input logic [XW-1:0] result,
    input logic          illegal
);

    logic is_packh, is_zext, is_word, is_rol0;

    always_comb begin
        is_packh = major_op == 7'b0110011 && func_hi == 7'b0000100 && minor_op == 3'b111;
        is_zext  = func_hi == 7'b0000100 && minor_op == 3'b100 && opnd_b == '0 &&
                   ((major_op == 7'b0110011 && !wide_mode) ||
                    (major_op == 7'b0111011 && wide_mode));
        is_word  = wide_mode && (major_op == 7'b0111011 || major_op == 7'b0011011) && !illegal;
        is_rol0  = wide_mode && major_op == 7'b0110011 && func_hi == 7'b0110000 &&
                   minor_op == 3'b001 && opnd_b[5:0] == 6'd0;

        AST_ILLEGAL_ZERO: assert (!illegal || result == '0)
            else $error("illegal encoding produced nonzero result"); // R9
        AST_NARROW_UPPER: assert (wide_mode || result[XW-1:HW] == '0)
            else $error("upper half nonzero in 32-bit mode"); // R10
        AST_WORD_SEXT: assert (!is_word || result[XW-1:HW] == {HW{result[HW-1]}})
            else $error("word result not sign-extended"); // R8
        AST_PACKH_HIGH: assert (!is_packh || result[XW-1:16] == '0)
            else $error("byte pack upper bits nonzero"); // R2
        AST_ZEXT_HALF: assert (!is_zext || result == {{(XW-16){1'b0}}, opnd_a[15:0]})
            else $error("halfword zero-extend mismatch"); // R4
        AST_ROT_ZERO: assert (!is_rol0 || result == opnd_a)
            else $error("rotate by zero changed operand"); // R6
    end

endmodule

bind pkb_alu pkb_alu_chk #(.XW(XW)) u_chk (
    .wide_mode (wide_mode),
    .major_op  (major_op),
    .minor_op  (minor_op),
    .func_hi   (func_hi),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/pkb_alu_test.sv
module pkb_alu_test;

    localparam logic [6:0] OPR  = 7'b0110011;
    localparam logic [6:0] OPW  = 7'b0111011;
    localparam logic [6:0] OPI  = 7'b0010011;
    localparam logic [6:0] OPIW = 7'b0011011;
    localparam logic [63:0] A = 64'h0123456789ABCDEF;
    localparam logic [63:0] B = 64'hFEDCBA9876543210;
    localparam logic [63:0] M = 64'h00FF00FF0F0F0F0F;

    typedef struct packed {
        logic        wm;
        logic [6:0]  maj;
        logic [2:0]  mn;
        logic [6:0]  up;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] res;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, OPR,  3'b100, 7'b0000100, A, B, 64'h7654321089ABCDEF, 1'b0, 4'd1},  // R1
        '{1'b0, OPR,  3'b100, 7'b0000100, A, B, 64'h000000003210CDEF, 1'b0, 4'd1},  // R1
        '{1'b1, OPR,  3'b111, 7'b0000100, A, B, 64'h00000000000010EF, 1'b0, 4'd2},  // R2
        '{1'b0, OPR,  3'b111, 7'b0000100, A, B, 64'h00000000000010EF, 1'b0, 4'd2},  // R2
        '{1'b1, OPW,  3'b100, 7'b0000100, A, B, 64'h000000003210CDEF, 1'b0, 4'd3},  // R3
        '{1'b1, OPW,  3'b100, 7'b0000100, B, A, 64'hFFFFFFFFCDEF3210, 1'b0, 4'd3},  // R3
        '{1'b0, OPW,  3'b100, 7'b0000100, A, B, 64'h0,                1'b1, 4'd3},  // R3
        '{1'b0, OPR,  3'b100, 7'b0000100, A, 64'h0, 64'h000000000000CDEF, 1'b0, 4'd4},  // R4
        '{1'b1, OPW,  3'b100, 7'b0000100, A, 64'h0, 64'h000000000000CDEF, 1'b0, 4'd4},  // R4
        '{1'b1, OPR,  3'b111, 7'b0100000, A, M, 64'h0100450080A0C0E0, 1'b0, 4'd5},  // R5
        '{1'b1, OPR,  3'b110, 7'b0100000, A, M, 64'hFF23FF67F9FBFDFF, 1'b0, 4'd5},  // R5
        '{1'b1, OPR,  3'b100, 7'b0100000, A, M, 64'hFE23BA67795B3D1F, 1'b0, 4'd5},  // R5
        '{1'b0, OPR,  3'b100, 7'b0100000, A, M, 64'h00000000795B3D1F, 1'b0, 4'd10}, // R10
        '{1'b0, OPR,  3'b111, 7'b0100000, A, M, 64'h0000000080A0C0E0, 1'b0, 4'd10}, // R10
        '{1'b1, OPR,  3'b001, 7'b0110000, A, 64'd4,  64'h123456789ABCDEF0, 1'b0, 4'd6},  // R6
        '{1'b1, OPR,  3'b001, 7'b0110000, A, 64'd68, 64'h123456789ABCDEF0, 1'b0, 4'd6},  // R6
        '{1'b1, OPR,  3'b101, 7'b0110000, A, 64'd8,  64'hEF0123456789ABCD, 1'b0, 4'd6},  // R6
        '{1'b0, OPR,  3'b001, 7'b0110000, A, 64'd36, 64'h000000009ABCDEF8, 1'b0, 4'd6},  // R6
        '{1'b0, OPR,  3'b101, 7'b0110000, A, 64'd0,  64'h0000000089ABCDEF, 1'b0, 4'd6},  // R6
        '{1'b1, OPI,  3'b101, 7'b0110001, A, 64'd36, 64'h789ABCDEF0123456, 1'b0, 4'd7},  // R7
        '{1'b0, OPI,  3'b101, 7'b0110001, A, 64'd36, 64'h0,                1'b1, 4'd7},  // R7
        '{1'b0, OPI,  3'b101, 7'b0110000, A, 64'd8,  64'h00000000EF89ABCD, 1'b0, 4'd7},  // R7
        '{1'b1, OPW,  3'b001, 7'b0110000, A, 64'd4,  64'hFFFFFFFF9ABCDEF8, 1'b0, 4'd8},  // R8
        '{1'b1, OPW,  3'b101, 7'b0110000, A, 64'd40, 64'hFFFFFFFFEF89ABCD, 1'b0, 4'd8},  // R8
        '{1'b1, OPIW, 3'b101, 7'b0110000, A, 64'd4,  64'hFFFFFFFFF89ABCDE, 1'b0, 4'd8},  // R8
        '{1'b1, OPW,  3'b001, 7'b0110000, 64'hFFFF000012345678, 64'd4, 64'h0000000023456781, 1'b0, 4'd8}, // R8
        '{1'b0, OPW,  3'b001, 7'b0110000, A, 64'd4,  64'h0, 1'b1, 4'd8},  // R8
        '{1'b1, OPR,  3'b000, 7'b0000100, A, B,      64'h0, 1'b1, 4'd9},  // R9
        '{1'b1, OPR,  3'b000, 7'b0100000, A, B,      64'h0, 1'b1, 4'd9},  // R9
        '{1'b1, OPI,  3'b001, 7'b0110000, A, B,      64'h0, 1'b1, 4'd9},  // R9
        '{1'b1, OPIW, 3'b101, 7'b0110001, A, 64'd4,  64'h0, 1'b1, 4'd9},  // R9
        '{1'b1, 7'b1111111, 3'b101, 7'b0110000, A, B, 64'h0, 1'b1, 4'd9}  // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_mode;
    logic [6:0]  major_op;
    logic [2:0]  minor_op;
    logic [6:0]  func_hi;
    logic [63:0] opnd_a, opnd_b, result;
    logic        illegal;
    int          n_chk = 0;
    int          n_err = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pkb_alu uut (
        .wide_mode (wide_mode),
        .major_op  (major_op),
        .minor_op  (minor_op),
        .func_hi   (func_hi),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .illegal   (illegal)
    );

    task automatic apply(input logic wm, input logic [6:0] maj, input logic [2:0] mn,
                         input logic [6:0] up, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        wide_mode = wm;
        major_op  = maj;
        minor_op  = mn;
        func_hi   = up;
        opnd_a    = a;
        opnd_b    = b;
        #5;
    endtask

    task automatic chk(input string tag, input logic [63:0] exp_r, input logic exp_i);
        n_chk++;
        if (result !== exp_r || illegal !== exp_i) begin
            n_err++;
            $display("FAIL %s: result %h illegal %0b, expected %h illegal %0b",
                     tag, result, illegal, exp_r, exp_i);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog expired: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        wide_mode = 1'b0;
        major_op  = '0;
        minor_op  = '0;
        func_hi   = '0;
        opnd_a    = '0;
        opnd_b    = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle inputs: all-zero fields are outside the slice (R9)
        apply(1'b0, 7'd0, 3'd0, 7'd0, 64'h0, 64'h0);
        chk("R9 reset-state idle inputs", 64'h0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].wm, VEC[i].maj, VEC[i].mn, VEC[i].up, VEC[i].a, VEC[i].b);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].res, VEC[i].ill);
        end

        // R10: upper operand bits flipped in 32-bit mode leave pack unchanged
        apply(1'b0, OPR, 3'b100, 7'b0000100, A ^ 64'hFFFFFFFF00000000, B ^ 64'hA5A5A5A500000000);
        chk("R10 upper operand bits ignored", 64'h000000003210CDEF, 1'b0);

        // R6: rotate right by width-1 equals rotate left by one
        apply(1'b1, OPR, 3'b101, 7'b0110000, A, 64'd63);
        chk("R6 ror by 63", 64'h02468ACF13579BDE, 1'b0);

        // R6: rotate left by zero in 64-bit mode returns operand
        apply(1'b1, OPR, 3'b001, 7'b0110000, B, 64'd128);
        chk("R6 rol by multiple of width", B, 1'b0);

        // R4 with operand A upper bits set: zext keeps only low halfword
        apply(1'b1, OPW, 3'b100, 7'b0000100, 64'hFFFFFFFFFFFF8001, 64'h0);
        chk("R4 zext with dirty upper bits", 64'h0000000000008001, 1'b0);

        // R7: immediate rotate with upper bit 0 clear in 64-bit mode, amount mod 64
        apply(1'b1, OPI, 3'b101, 7'b0110000, A, 64'd72);
        chk("R7 rori amount modulo 64", 64'hEF0123456789ABCD, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule